// File: doc/BRIEF.md
# RV32I Control Decoder with Branch Resolution

This block is the control unit of a single-cycle RV32I datapath. It looks at one 32-bit instruction word and at two status flags from the ALU, and it produces every control the datapath needs in the same cycle:

- the register write enable;
- the immediate format;
- the two ALU operand sources;
- a 4-bit ALU operation;
- the memory write enable;
- the writeback source;
- the next-PC source.

The block is purely combinational. The register file, ALU, memories, immediate generator and PC adders sit outside it.

Decoding happens in two stages. A primary stage sorts the opcode into an instruction kind and sets the base controls. It also checks whether funct3 is allowed for loads, stores and register jumps. A secondary stage turns funct3 and funct7 into the ALU operation and flags illegal function encodings. A small resolver decides whether a conditional branch is taken. It uses only the ALU zero flag and bit 0 of the ALU result.

Anything the block does not recognise leaves no architectural trace. This covers unknown opcodes, system and fence opcodes, and illegal funct fields. In all of these cases the outputs collapse to a no-operation bundle: both write enables low and the sequential PC selected. Since the block has no data stream, all pins are plain level signals and there is no back-pressure.

Top module: `rv_ctrl_unit`

## Requirements
- R1: Any opcode other than the nine supported ones produces the no-operation bundle. This includes the system opcode 1110011 and the fence opcode 0001111. The bundle is: reg_we=0, imm_sel=0, alu_src_a=0, alu_src_b=0, alu_op=0, mem_we=0, wb_sel=0, pc_sel=0.
- R2: Register-register opcode 0110011 sets reg_we=1 with both operands from registers (alu_src_a=0 rs1, alu_src_b=0 rs2) and wb_sel=0 (ALU). The alu_op codes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, SLT=5, SLTU=6, SLL=7, SRL=8, SRA=9. funct3 selects 000 add/sub, 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL/SRA, 110 OR, 111 AND. For 000 and 101, funct7 0100000 selects SUB and SRA respectively.
- R3: A register-register instruction is legal only in two cases: funct7 is 0000000, or funct7 is 0100000 with funct3 000 or 101. Any other encoding gives the no-operation bundle.
- R4: Immediate ALU opcode 0010011 sets reg_we=1, alu_src_b=1 (immediate) and imm_sel=0 (I format). It uses the R2 operation map, except that funct3 000 is always ADD.
- R5: The immediate shifts are illegal in two cases and then give the no-operation bundle. One is funct3 001 with funct7 other than 0000000. The other is funct3 101 with funct7 other than 0000000 or 0100000.
- R6: Load opcode 0000011 with funct3 000, 001, 010, 100 or 101 sets reg_we=1, alu_src_b=1, alu_op ADD, imm_sel=0 and wb_sel=1 (memory). Any other funct3 gives the no-operation bundle.
- R7: Store opcode 0100011 with funct3 000, 001 or 010 sets mem_we=1, reg_we=0, imm_sel=1 (S format), alu_src_b=1 and alu_op ADD. Any other funct3 gives the no-operation bundle.
- R8: Branch opcode 1100011 sets imm_sel=2 (B format), register operands and reg_we=0. The ALU operation is SUB for funct3 000/001, SLT for 100/101 and SLTU for 110/111.
- R9: A branch sets pc_sel=1 (PC plus immediate) when taken and pc_sel=0 otherwise. The taken conditions are:
  - funct3 000 is taken when zero=1, and 001 when zero=0.
  - funct3 100 and 110 are taken when the result bit 0 flag is 1.
  - funct3 101 and 111 are taken when that flag is 0.
- R10: Branch funct3 010 and 011 give the no-operation bundle whatever the flags.
- R11: JAL opcode 1101111 sets reg_we=1, imm_sel=3 (J format), wb_sel=2 (PC+4) and pc_sel=1.
- R12: JALR opcode 1100111 with funct3 000 sets reg_we=1, alu_src_a=0, alu_src_b=1, imm_sel=0, alu_op ADD, wb_sel=2 and pc_sel=2. The value 2 means the ALU result with bit 0 cleared. Any other funct3 gives the no-operation bundle.
- R13: LUI 0110111 and AUIPC 0010111 both set reg_we=1, imm_sel=4 (U format), alu_src_b=1 and alu_op ADD. Operand A is alu_src_a=2 (constant zero) for LUI and alu_src_a=1 (PC) for AUIPC.
- R14: The flags alu_zero and alu_lsb change no output for any instruction that is not a legal branch. The rd, rs1 and rs2 fields never change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| alu_zero | input | 1 | ALU result equals zero |
| alu_lsb | input | 1 | Bit 0 of the ALU result |
| reg_we | output | 1 | Register file write enable |
| imm_sel | output | 3 | Immediate format: 0 I, 1 S, 2 B, 3 J, 4 U |
| alu_src_a | output | 2 | Operand A: 0 rs1, 1 PC, 2 zero |
| alu_src_b | output | 1 | Operand B: 0 rs2, 1 immediate |
| alu_op | output | 4 | ALU operation code (see R2) |
| mem_we | output | 1 | Data memory write enable |
| wb_sel | output | 2 | Writeback source: 0 ALU, 1 memory, 2 PC+4 |
| pc_sel | output | 2 | Next PC: 0 PC+4, 1 PC+immediate, 2 ALU result with bit 0 cleared |

## Verification
The main sweep covers every 7-bit opcode with every funct3 and every combination of the two flags. It pairs each of these with six funct7 values: 0000000 and 0100000, which are the legal ones, plus 0000001, 1000000, 1100000 and 1111111. This separates legal from illegal shift and register encodings (R3, R5). It also shows that unsupported opcodes, including system and fence, decode to nothing (R1). The four flag combinations show that branch conditions follow the right flag with the right polarity (R9). They also show that the flags leave all other instructions unchanged (R14). The rd, rs1 and rs2 fields are filled from a pseudo-random sequence, so any dependence on them shows up as a miscompare.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int ILEN = 32;
  localparam int OPW  = 7;
  localparam int F3W  = 3;
  localparam int F7W  = 7;
  localparam int AOPW = 4;

  localparam int F3_LSB = 12;
  localparam int F7_LSB = 25;

  localparam logic [OPW-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPW-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPW-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPW-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPW-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPW-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPW-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPW-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPW-1:0] OPC_AUIPC  = 7'b0010111;

  localparam logic [F7W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [AOPW-1:0] {
    AOP_ADD = 4'd0, AOP_SUB = 4'd1, AOP_AND = 4'd2, AOP_OR  = 4'd3,
    AOP_XOR = 4'd4, AOP_SLT = 4'd5, AOP_SLTU = 4'd6, AOP_SLL = 4'd7,
    AOP_SRL = 4'd8, AOP_SRA = 4'd9
  } aop_e;

  typedef enum logic [2:0] {
    IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_J = 3'd3, IMM_U = 3'd4
  } imm_e;

  typedef enum logic [1:0] {SA_RS1 = 2'd0, SA_PC = 2'd1, SA_ZERO = 2'd2} srca_e;
  typedef enum logic       {SB_RS2 = 1'b0, SB_IMM = 1'b1} srcb_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2} wb_e;
  typedef enum logic [1:0] {NPC_SEQ = 2'd0, NPC_REL = 2'd1, NPC_REG = 2'd2} npc_e;

  typedef enum logic [3:0] {
    K_NONE, K_REG, K_IMM, K_LOAD, K_STORE, K_BRANCH, K_JAL, K_JALR, K_LUI, K_AUIPC
  } kind_e;

  typedef struct packed {
    logic  reg_we;
    imm_e  imm;
    srca_e sa;
    srcb_e sb;
    aop_e  aop;
    logic  mem_we;
    wb_e   wb;
    npc_e  npc;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    reg_we: 1'b0, imm: IMM_I, sa: SA_RS1, sb: SB_RS2, aop: AOP_ADD,
    mem_we: 1'b0, wb: WB_ALU, npc: NPC_SEQ
  };
endpackage

// File: rtl/rvdec_opcode.sv
module rvdec_opcode
  import rvdec_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [F3W-1:0] funct3,
  output kind_e          kind,
  output ctrl_t          base,
  output logic           f3_ok
);
  always_comb begin
    kind  = K_NONE;
    base  = CTRL_NOP;
    f3_ok = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        kind        = K_REG;
        base.reg_we = 1'b1;
      end
      OPC_IMM: begin
        kind        = K_IMM;
        base.reg_we = 1'b1;
        base.sb     = SB_IMM;
      end
      OPC_LOAD: begin
        kind        = K_LOAD;
        base.reg_we = 1'b1;
        base.sb     = SB_IMM;
        base.wb     = WB_MEM;
        f3_ok       = (funct3 != 3'b011) && (funct3 != 3'b110) && (funct3 != 3'b111);
      end
      OPC_STORE: begin
        kind        = K_STORE;
        base.imm    = IMM_S;
        base.sb     = SB_IMM;
        base.mem_we = 1'b1;
        f3_ok       = (funct3[2] == 1'b0) && (funct3 != 3'b011);
      end
      OPC_BRANCH: begin
        kind     = K_BRANCH;
        base.imm = IMM_B;
      end
      OPC_JAL: begin
        kind        = K_JAL;
        base.reg_we = 1'b1;
        base.imm    = IMM_J;
        base.wb     = WB_PC4;
        base.npc    = NPC_REL;
      end
      OPC_JALR: begin
        kind        = K_JALR;
        base.reg_we = 1'b1;
        base.sb     = SB_IMM;
        base.wb     = WB_PC4;
        base.npc    = NPC_REG;
        f3_ok       = (funct3 == 3'b000);
      end
      OPC_LUI: begin
        kind        = K_LUI;
        base.reg_we = 1'b1;
        base.imm    = IMM_U;
        base.sa     = SA_ZERO;
        base.sb     = SB_IMM;
      end
      OPC_AUIPC: begin
        kind        = K_AUIPC;
        base.reg_we = 1'b1;
        base.imm    = IMM_U;
        base.sa     = SA_PC;
        base.sb     = SB_IMM;
      end
      default: begin
        kind  = K_NONE;
        f3_ok = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rvdec_alu.sv
module rvdec_alu
  import rvdec_pkg::*;
(
  input  kind_e          kind,
  input  logic [F3W-1:0] funct3,
  input  logic [F7W-1:0] funct7,
  output aop_e           aop,
  output logic           fn_ok
);
  logic f7_base, f7_alt;
  aop_e arith;

  assign f7_base = (funct7 == F7_BASE);
  assign f7_alt  = (funct7 == F7_ALT);

  // operation picked by funct3, with funct7 bit 5 choosing the alternate form
  always_comb begin
    unique case (funct3)
      3'b000:  arith = (kind == K_REG && funct7[5]) ? AOP_SUB : AOP_ADD;
      3'b001:  arith = AOP_SLL;
      3'b010:  arith = AOP_SLT;
      3'b011:  arith = AOP_SLTU;
      3'b100:  arith = AOP_XOR;
      3'b101:  arith = funct7[5] ? AOP_SRA : AOP_SRL;
      3'b110:  arith = AOP_OR;
      default: arith = AOP_AND;
    endcase
  end

  always_comb begin
    aop   = AOP_ADD;
    fn_ok = 1'b1;
    case (kind)
      K_REG: begin
        aop   = arith;
        fn_ok = f7_base || (f7_alt && (funct3 == 3'b000 || funct3 == 3'b101));
      end
      K_IMM: begin
        aop = arith;
        if (funct3 == 3'b001)      fn_ok = f7_base;
        else if (funct3 == 3'b101) fn_ok = f7_base || f7_alt;
        else                       fn_ok = 1'b1;
      end
      K_BRANCH: begin
        if (funct3[2] == 1'b0) begin
          aop   = AOP_SUB;
          fn_ok = (funct3[1] == 1'b0);
        end else begin
          aop   = funct3[1] ? AOP_SLTU : AOP_SLT;
          fn_ok = 1'b1;
        end
      end
      default: begin
        aop   = AOP_ADD;
        fn_ok = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rvdec_branch.sv
module rvdec_branch
  import rvdec_pkg::*;
(
  input  logic           is_branch,
  input  logic [F3W-1:0] funct3,
  input  logic           zero,
  input  logic           lsb,
  output logic           taken
);
  logic cond;

  // funct3[2] picks the flag, funct3[0] inverts the sense
  assign cond  = funct3[2] ? lsb : zero;
  assign taken = is_branch && (cond ^ funct3[0]);
endmodule

// File: rtl/rv_ctrl_unit.sv
module rv_ctrl_unit
  import rvdec_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        alu_zero,
  input  logic        alu_lsb,
  output logic        reg_we,
  output logic [2:0]  imm_sel,
  output logic [1:0]  alu_src_a,
  output logic        alu_src_b,
  output logic [3:0]  alu_op,
  output logic        mem_we,
  output logic [1:0]  wb_sel,
  output logic [1:0]  pc_sel
);
  logic [OPW-1:0] opcode;
  logic [F3W-1:0] funct3;
  logic [F7W-1:0] funct7;
  kind_e          kind;
  ctrl_t          base;
  ctrl_t          ctrl;
  aop_e           aop;
  logic           f3_ok;
  logic           fn_ok;
  logic           taken;

  assign opcode = instr[OPW-1:0];
  assign funct3 = instr[F3_LSB +: F3W];
  assign funct7 = instr[F7_LSB +: F7W];

  rvdec_opcode u_opc (
    .opcode (opcode),
    .funct3 (funct3),
    .kind   (kind),
    .base   (base),
    .f3_ok  (f3_ok)
  );

  rvdec_alu u_alu (
    .kind   (kind),
    .funct3 (funct3),
    .funct7 (funct7),
    .aop    (aop),
    .fn_ok  (fn_ok)
  );

  rvdec_branch u_br (
    .is_branch (kind == K_BRANCH),
    .funct3    (funct3),
    .zero      (alu_zero),
    .lsb       (alu_lsb),
    .taken     (taken)
  );

  always_comb begin
    ctrl = CTRL_NOP;
    if (f3_ok && fn_ok) begin
      ctrl     = base;
      ctrl.aop = aop;
      if (kind == K_BRANCH) ctrl.npc = taken ? NPC_REL : NPC_SEQ;
    end
  end

  assign reg_we    = ctrl.reg_we;
  assign imm_sel   = ctrl.imm;
  assign alu_src_a = ctrl.sa;
  assign alu_src_b = ctrl.sb;
  assign alu_op    = ctrl.aop;
  assign mem_we    = ctrl.mem_we;
  assign wb_sel    = ctrl.wb;
  assign pc_sel    = ctrl.npc;
endmodule

// File: rtl/rv_ctrl_unit_chk.sv
module rv_ctrl_unit_chk (
  input logic [31:0] instr,
  input logic        alu_zero,
  input logic        alu_lsb,
  input logic        reg_we,
  input logic [2:0]  imm_sel,
  input logic [1:0]  alu_src_a,
  input logic        alu_src_b,
  input logic [3:0]  alu_op,
  input logic        mem_we,
  input logic [1:0]  wb_sel,
  input logic [1:0]  pc_sel
);
  logic [6:0] opc;
  logic       known;
  assign opc   = instr[6:0];
  assign known = (opc == 7'b0110011) || (opc == 7'b0010011) || (opc == 7'b0000011) ||
                 (opc == 7'b0100011) || (opc == 7'b1100011) || (opc == 7'b1101111) ||
                 (opc == 7'b1100111) || (opc == 7'b0110111) || (opc == 7'b0010111);

  always_comb begin
    assert_unknown_opcode_silent_R1: assert (known || (!reg_we && !mem_we && pc_sel == 2'd0))
      else $error("unknown opcode produced a side effect");
    assert_store_never_writes_reg_R7: assert (!mem_we || (opc == 7'b0100011 && !reg_we))
      else $error("memory write outside a store");
    if (opc == 7'b1100011 && instr[14:12] == 3'b000)
      assert_beq_follows_zero_R9: assert (pc_sel == (alu_zero ? 2'd1 : 2'd0))
        else $error("equal-branch ignores zero flag");
    if (opc == 7'b1100011 && instr[14:12] == 3'b101)
      assert_bge_follows_lsb_R9: assert (pc_sel == (alu_lsb ? 2'd0 : 2'd1))
        else $error("greater-equal branch ignores result bit 0");
    assert_reg_target_links_R12: assert (pc_sel != 2'd2 || (reg_we && wb_sel == 2'd2 && opc == 7'b1100111))
      else $error("register jump without link");
    if (opc == 7'b0110111)
      assert_lui_zero_base_R13: assert (alu_src_a == 2'd2 && imm_sel == 3'd4)
        else $error("upper immediate load not based on zero");
    assert_no_write_on_branch_R8: assert (opc != 7'b1100011 || (!reg_we && !mem_we))
      else $error("branch writes state");
  end
endmodule

bind rv_ctrl_unit rv_ctrl_unit_chk u_chk (
  .instr     (instr),
  .alu_zero  (alu_zero),
  .alu_lsb   (alu_lsb),
  .reg_we    (reg_we),
  .imm_sel   (imm_sel),
  .alu_src_a (alu_src_a),
  .alu_src_b (alu_src_b),
  .alu_op    (alu_op),
  .mem_we    (mem_we),
  .wb_sel    (wb_sel),
  .pc_sel    (pc_sel)
);

// File: tb/test_rv_ctrl_unit.sv
module test_rv_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        alu_zero, alu_lsb;
  logic        reg_we, alu_src_b, mem_we;
  logic [2:0]  imm_sel;
  logic [1:0]  alu_src_a, wb_sel, pc_sel;
  logic [3:0]  alu_op;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  rv_ctrl_unit i_rv_ctrl_unit (
    .instr(instr), .alu_zero(alu_zero), .alu_lsb(alu_lsb),
    .reg_we(reg_we), .imm_sel(imm_sel), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .alu_op(alu_op), .mem_we(mem_we),
    .wb_sel(wb_sel), .pc_sel(pc_sel)
  );

  // alu code for a funct3 with the alternate funct7 form
  function automatic logic [3:0] op_of(input logic [2:0] f3, input logic alt);
    case (f3)
      3'd0: return alt ? 4'd1 : 4'd0;
      3'd1: return 4'd7;
      3'd2: return 4'd5;
      3'd3: return 4'd6;
      3'd4: return 4'd4;
      3'd5: return alt ? 4'd9 : 4'd8;
      3'd6: return 4'd3;
      default: return 4'd2;
    endcase
  endfunction

  // packed as {reg_we, imm_sel, src_a, src_b, alu_op, mem_we, wb_sel, pc_sel}
  function automatic logic [15:0] model(input logic [31:0] ins, input logic z, input logic l);
    logic [6:0] op = ins[6:0];
    logic [2:0] f3 = ins[14:12];
    logic [6:0] f7 = ins[31:25];
    logic rw = 0, sb = 0, mw = 0, tk = 0;
    logic [2:0] im = 0;
    logic [1:0] sa = 0, wb = 0, np = 0;
    logic [3:0] ao = 0;
    case (op)
      7'h33: if (f7 == 7'h00 || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5))) begin
        rw = 1; ao = op_of(f3, f7[5]);
      end
      7'h13: if ((f3 == 3'd1) ? (f7 == 7'h00) :
                 (f3 == 3'd5) ? (f7 == 7'h00 || f7 == 7'h20) : 1'b1) begin
        rw = 1; sb = 1; ao = (f3 == 3'd0) ? 4'd0 : op_of(f3, f7[5]);
      end
      7'h03: if (f3 == 0 || f3 == 1 || f3 == 2 || f3 == 4 || f3 == 5) begin
        rw = 1; sb = 1; wb = 1;
      end
      7'h23: if (f3 < 3) begin im = 1; sb = 1; mw = 1; end
      7'h63: if (f3 != 2 && f3 != 3) begin
        im = 2;
        ao = (f3 < 2) ? 4'd1 : (f3 < 6) ? 4'd5 : 4'd6;
        case (f3)
          3'd0: tk = z;
          3'd1: tk = !z;
          3'd4, 3'd6: tk = l;
          default: tk = !l;
        endcase
        np = tk ? 2'd1 : 2'd0;
      end
      7'h6F: begin rw = 1; im = 3; wb = 2; np = 1; end
      7'h67: if (f3 == 0) begin rw = 1; sb = 1; wb = 2; np = 2; end
      7'h37: begin rw = 1; im = 4; sa = 2; sb = 1; end
      7'h17: begin rw = 1; im = 4; sa = 1; sb = 1; end
      default: ;
    endcase
    return {rw, im, sa, sb, ao, mw, wb, np};
  endfunction

  function automatic string tag(input logic [6:0] op, input logic [2:0] f3);
    case (op)
      7'h33: return "R2/R3/R14";
      7'h13: return (f3 == 1 || f3 == 5) ? "R5/R14" : "R4/R14";
      7'h03: return "R6/R14";
      7'h23: return "R7/R14";
      7'h63: return (f3 == 2 || f3 == 3) ? "R10" : "R8/R9";
      7'h6F: return "R11/R14";
      7'h67: return "R12/R14";
      7'h37, 7'h17: return "R13/R14";
      default: return "R1/R14";
    endcase
  endfunction

  task automatic apply(input logic [31:0] ins, input logic z, input logic l);
    logic [15:0] exp, act;
    @(posedge clk);
    #1;
    instr = ins; alu_zero = z; alu_lsb = l;
    @(negedge clk);
    exp = model(ins, z, l);
    act = {reg_we, imm_sel, alu_src_a, alu_src_b, alu_op, mem_we, wb_sel, pc_sel};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s instr=%h z=%0b l=%0b actual=%h expected=%h",
               tag(ins[6:0], ins[14:12]), ins, z, l, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [6:0] f7s [6] = '{7'h00, 7'h20, 7'h01, 7'h40, 7'h60, 7'h7F};
    rst_n = 1'b0; instr = '0; alu_zero = 1'b0; alu_lsb = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: all-zero word after reset decodes to the no-operation bundle
    apply(32'h0000_0000, 1'b0, 1'b0);
    for (int op = 0; op < 128; op++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int k = 0; k < 6; k++)
          for (int fl = 0; fl < 4; fl++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply({f7s[k], lfsr[14:10], lfsr[24:20], 3'(f3), lfsr[4:0], 7'(op)},
                  fl[1], fl[0]);
          end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule